// File: doc/BRIEF.md
# Quadrature Decoder Position Counter

This block turns already-conditioned phase A, phase B and index levels into a signed-agnostic 32-bit up/down position count. It decodes full quadrature (four counts per cycle) or half quadrature (phase A edges only). It also has three pulse-style schemes: up/down pulse pairs, pulse plus direction level, and pulse with a selectable direction source. The compare-bounded variants wrap at a programmable maximum instead of at the full range.

Around the counter sit a compare match and an index event. The index event can reload the count, with the reload value depending on direction, and can do this on every index or only on the first one. The index can also latch the count into a register. A capture path copies the count into a hold register on a software request or on a rising external request. Sticky flags are cleared by writing ones, and each flag has an enable bit toward a single interrupt line.

Software reaches the block through a one-cycle write strobe with a 3-bit select. The encodings are: 0 = count, 1 = compare, 2 = maximum, 3 = control, 4 = flag clear, 5 = hold request.

Top module: `qdec_poscnt`

## Requirements
- R1: After a synchronous reset the count, hold and latch registers are 0, the direction output is 1 (up), all flags are 0 and the interrupt is low.
- R2: Control bit 0 enables the block. A write with select 0 loads the count only while the block is disabled and is ignored while it is enabled. While disabled, phase activity never changes the count.
- R3: Mode field control[3:1] = 000 (free) or 010 (bounded) counts every A and B edge. An A edge counts up when the new A differs from B. A B edge counts up when the new B equals A. Each counted event sets the direction output to its direction.
- R4: Mode 001 (free) or 011 (bounded) counts only A edges, with the same direction rule as R3. B edges alone leave the count unchanged.
- R5: Free modes wrap from all ones to 0 and back. Bounded modes wrap from the maximum register to 0 and from 0 to the maximum. Every wrap sets flag bit 2.
- R6: With control bit 4 set, any update that makes the count equal to the compare register sets flag bit 1.
- R7: With control bit 5 set, a rising index edge loads 0 when the direction is up and the maximum when it is down. With control bit 6 also set, only the first such edge after enabling reloads, and the first-index output goes high when it does.
- R8: Each rising index edge while enabled sets flag bit 0. With control bit 7 set, the same edge copies the pre-update count into the latch register.
- R9: A software hold request (select 5, data bit 0 = 1) or a low-to-high transition of the external hold request copies the count into the hold register. A hold request that stays high captures nothing more.
- R10: A counted event whose direction differs from the direction output sets flag bit 3. In modes 000 to 011, A and B changing in the same sample set flag bit 4 and do not count. Flags stay set until a write with select 4 has a 1 in their bit; a set in the same cycle wins.
- R11: The interrupt is high exactly when some flag bit i is set and its enable, control bit 12+i, is set.
- R12: Modes 100, 101 and 110 count A pulses chosen by the rate field control[9:8]: 00 = falling, 01 = rising, 10 = both. Mode 100 counts A pulses up and B pulses down. Mode 101 takes the direction from the B level (1 = up). Mode 110 takes the direction from field control[11:10]: 10 = up, 11 = down, otherwise the B level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ph_a | input | 1 | Conditioned phase A level |
| ph_b | input | 1 | Conditioned phase B level |
| ph_idx | input | 1 | Conditioned index level |
| hold_req | input | 1 | External capture request, acts on its rising edge |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select for the write |
| wr_data | input | W | Write data |
| count | output | W | Position count |
| hold_val | output | W | Captured count from the hold path |
| latch_val | output | W | Count latched by the index |
| dir_up | output | 1 | Current direction, 1 = up |
| flags | output | 5 | Sticky flags: 0 index, 1 compare, 2 wrap, 3 direction change, 4 phase error |
| first_idx_done | output | 1 | First-index reload has occurred |
| irq | output | 1 | Combined interrupt |

## Verification
Some properties are checked on every cycle. Flags never drop without a clearing write. A disabled block holds its count unless software writes it. A bounded count that starts inside its range never leaves it. A change of direction always leaves its flag set, the hold register moves only after a request, and the first-index output rises only under the first-only option. The exact count reached, the reload value chosen by direction, and the latched and held values can only be shown by the bench's phase sequences. The same holds for edge selection in the pulse modes and for the wrap points.

// File: rtl/qdec_pkg.sv
package qdec_pkg;

    typedef enum logic [2:0] {
        M_X4_FREE = 3'b000,
        M_X2_FREE = 3'b001,
        M_X4_BND  = 3'b010,
        M_X2_BND  = 3'b011,
        M_PULSE1  = 3'b100,
        M_PULSE2  = 3'b101,
        M_DIRCNT  = 3'b110,
        M_RSVD    = 3'b111
    } mode_e;

    typedef enum logic [2:0] {
        SEL_COUNT = 3'd0,
        SEL_CMP   = 3'd1,
        SEL_MAX   = 3'd2,
        SEL_CTRL  = 3'd3,
        SEL_FCLR  = 3'd4,
        SEL_HOLD  = 3'd5
    } sel_e;

    localparam int NFLAG     = 5;
    localparam int FL_IDX    = 0;
    localparam int FL_CMP    = 1;
    localparam int FL_WRAP   = 2;
    localparam int FL_DIRCHG = 3;
    localparam int FL_PERR   = 4;

    typedef struct packed {
        logic [NFLAG-1:0] ien;
        logic [1:0]       dsrc;
        logic [1:0]       rate;
        logic             latch_en;
        logic             first_only;
        logic             reload_en;
        logic             cmp_en;
        mode_e            mode;
        logic             enable;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    function automatic logic is_bounded(mode_e m);
        return (m == M_X4_BND) || (m == M_X2_BND);
    endfunction

    function automatic logic pick_edge(logic [1:0] rate, logic chg, logic lvl);
        case (rate)
            2'b00:   return chg & ~lvl;
            2'b01:   return chg & lvl;
            default: return chg;
        endcase
    endfunction

endpackage

// File: rtl/qdec_sampler.sv
module qdec_sampler #(
    parameter int NCH = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] lvl,
    output logic [NCH-1:0] chg
);
    for (genvar i = 0; i < NCH; i++) begin : g_ch
        logic prev;
        always_ff @(posedge clk) begin
            if (rst) prev <= 1'b0;
            else     prev <= lvl[i];
        end
        assign chg[i] = lvl[i] ^ prev;
    end
endmodule

// File: rtl/qdec_decode.sv
module qdec_decode
    import qdec_pkg::*;
(
    input  mode_e      mode,
    input  logic [1:0] rate,
    input  logic [1:0] dsrc,
    input  logic       a,
    input  logic       b,
    input  logic       chg_a,
    input  logic       chg_b,
    output logic       step,
    output logic       up,
    output logic       perr
);
    logic pa, pb;
    assign pa = pick_edge(rate, chg_a, a);
    assign pb = pick_edge(rate, chg_b, b);

    always_comb begin
        step = 1'b0;
        up   = 1'b1;
        perr = 1'b0;
        case (mode)
            M_X4_FREE, M_X4_BND: begin
                if (chg_a && chg_b) perr = 1'b1;
                else if (chg_a) begin step = 1'b1; up = a ^ b;    end
                else if (chg_b) begin step = 1'b1; up = ~(a ^ b); end
            end
            M_X2_FREE, M_X2_BND: begin
                if (chg_a && chg_b) perr = 1'b1;
                else if (chg_a) begin step = 1'b1; up = a ^ b; end
            end
            M_PULSE1: begin
                if (pa && !pb)      begin step = 1'b1; up = 1'b1; end
                else if (pb && !pa) begin step = 1'b1; up = 1'b0; end
            end
            M_PULSE2: begin
                if (pa) begin step = 1'b1; up = b; end
            end
            M_DIRCNT: begin
                if (pa) begin
                    step = 1'b1;
                    case (dsrc)
                        2'b10:   up = 1'b1;
                        2'b11:   up = 1'b0;
                        default: up = b;
                    endcase
                end
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/qdec_step.sv
module qdec_step #(
    parameter int W = 32
) (
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] limit,
    input  logic         up,
    output logic [W-1:0] nxt,
    output logic         wrap
);
    always_comb begin
        if (up) begin
            wrap = (cnt == limit);
            nxt  = wrap ? '0 : cnt + 1'b1;
        end else begin
            wrap = (cnt == '0);
            nxt  = wrap ? limit : cnt - 1'b1;
        end
    end
endmodule

// File: rtl/qdec_poscnt.sv
module qdec_poscnt
    import qdec_pkg::*;
#(
    parameter int W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ph_a,
    input  logic             ph_b,
    input  logic             ph_idx,
    input  logic             hold_req,
    input  logic             wr_en,
    input  logic [2:0]       wr_sel,
    input  logic [W-1:0]     wr_data,
    output logic [W-1:0]     count,
    output logic [W-1:0]     hold_val,
    output logic [W-1:0]     latch_val,
    output logic             dir_up,
    output logic [NFLAG-1:0] flags,
    output logic             first_idx_done,
    output logic             irq
);
    localparam int NCH = 4;

    ctrl_t            ctrl_r;
    logic [W-1:0]     count_r, cmp_r, max_r, hold_r, latch_r;
    logic             dir_r, first_done;
    logic [NFLAG-1:0] flags_r;

    logic [NCH-1:0]   chg;
    logic             step, up, perr, wrap;
    logic [W-1:0]     limit, nxt, new_cnt, reload_val;
    logic             idx_ev, reload_go, cnt_step, upd, hold_go;
    logic [NFLAG-1:0] fset, fclr;

    qdec_sampler #(.NCH(NCH)) u_samp (
        .clk (clk),
        .rst (rst),
        .lvl ({hold_req, ph_idx, ph_b, ph_a}),
        .chg (chg)
    );

    qdec_decode u_dec (
        .mode  (ctrl_r.mode),
        .rate  (ctrl_r.rate),
        .dsrc  (ctrl_r.dsrc),
        .a     (ph_a),
        .b     (ph_b),
        .chg_a (chg[0]),
        .chg_b (chg[1]),
        .step  (step),
        .up    (up),
        .perr  (perr)
    );

    assign limit = is_bounded(ctrl_r.mode) ? max_r : {W{1'b1}};

    qdec_step #(.W(W)) u_step (
        .cnt   (count_r),
        .limit (limit),
        .up    (up),
        .nxt   (nxt),
        .wrap  (wrap)
    );

    always_comb begin
        idx_ev     = ctrl_r.enable && chg[2] && ph_idx;
        reload_go  = idx_ev && ctrl_r.reload_en && !(ctrl_r.first_only && first_done);
        reload_val = dir_r ? '0 : max_r;
        cnt_step   = ctrl_r.enable && step && !reload_go;
        upd        = reload_go || cnt_step;
        new_cnt    = reload_go ? reload_val : nxt;
        hold_go    = (chg[3] && hold_req) || (wr_en && wr_sel == SEL_HOLD && wr_data[0]);

        fset            = '0;
        fset[FL_IDX]    = idx_ev;
        fset[FL_CMP]    = ctrl_r.enable && ctrl_r.cmp_en && upd && (new_cnt == cmp_r);
        fset[FL_WRAP]   = cnt_step && wrap;
        fset[FL_DIRCHG] = cnt_step && (up != dir_r);
        fset[FL_PERR]   = ctrl_r.enable && perr;

        fclr = (wr_en && wr_sel == SEL_FCLR) ? wr_data[NFLAG-1:0] : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_r     <= '0;
            count_r    <= '0;
            cmp_r      <= '0;
            max_r      <= '0;
            hold_r     <= '0;
            latch_r    <= '0;
            dir_r      <= 1'b1;
            first_done <= 1'b0;
            flags_r    <= '0;
        end else begin
            if (wr_en && wr_sel == SEL_CMP)  cmp_r  <= wr_data;
            if (wr_en && wr_sel == SEL_MAX)  max_r  <= wr_data;
            if (wr_en && wr_sel == SEL_CTRL) ctrl_r <= ctrl_t'(wr_data[CTRL_W-1:0]);

            if (!ctrl_r.enable) begin
                first_done <= 1'b0;
                if (wr_en && wr_sel == SEL_COUNT) count_r <= wr_data;
            end else begin
                if (upd) count_r <= new_cnt;
                if (reload_go && ctrl_r.first_only) first_done <= 1'b1;
            end

            if (cnt_step)                   dir_r   <= up;
            if (idx_ev && ctrl_r.latch_en)  latch_r <= count_r;
            if (hold_go)                    hold_r  <= count_r;

            flags_r <= (flags_r & ~fclr) | fset;
        end
    end

    assign count          = count_r;
    assign hold_val       = hold_r;
    assign latch_val      = latch_r;
    assign dir_up         = dir_r;
    assign flags          = flags_r;
    assign first_idx_done = first_done;
    assign irq            = |(flags_r & ctrl_r.ien);

endmodule

// File: rtl/qdec_chk.sv
module qdec_chk
    import qdec_pkg::*;
#(
    parameter int W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic [2:0]       wr_sel,
    input logic [NFLAG-1:0] wr_lo,
    input logic             hold_req,
    input logic             enable,
    input mode_e            mode,
    input logic             first_only,
    input logic [W-1:0]     count,
    input logic [W-1:0]     max_r,
    input logic [W-1:0]     hold_val,
    input logic             dir_up,
    input logic [NFLAG-1:0] flags,
    input logic             first_done,
    input logic             irq
);
    logic [NFLAG-1:0] keep;
    assign keep = flags & ~((wr_en && wr_sel == SEL_FCLR) ? wr_lo : '0);

    // R10: a set flag survives unless its bit is written with 1
    assert_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((flags & $past(keep)) == $past(keep)));

    // R10: any direction change leaves the direction-change flag set
    assert_dirchg_R10: assert property (@(posedge clk) disable iff (rst)
        !$stable(dir_up) |-> flags[FL_DIRCHG]);

    // R11: the interrupt needs a pending flag
    assert_irq_src_R11: assert property (@(posedge clk) disable iff (rst)
        irq |-> (flags != '0));

    // R2: disabled block keeps its count unless software writes it
    assert_frozen_R2: assert property (@(posedge clk) disable iff (rst)
        (!enable && !(wr_en && wr_sel == SEL_COUNT)) |=> $stable(count));

    // R5: a bounded count inside its range stays inside it
    assert_bound_R5: assert property (@(posedge clk) disable iff (rst)
        (enable && is_bounded(mode) && count <= max_r &&
         !(wr_en && (wr_sel == SEL_MAX || wr_sel == SEL_CTRL)))
        |=> (count <= $past(max_r)));

    // R7: the first-index output rises only under the first-only option
    assert_first_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(first_done) |-> $past(first_only));

    // R9: the hold register moves only after a request
    assert_hold_src_R9: assert property (@(posedge clk) disable iff (rst)
        !$stable(hold_val) |-> ($past(wr_en && wr_sel == SEL_HOLD && wr_lo[0]) || $past(hold_req)));
endmodule

bind qdec_poscnt qdec_chk #(.W(W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_sel     (wr_sel),
    .wr_lo      (wr_data[NFLAG-1:0]),
    .hold_req   (hold_req),
    .enable     (ctrl_r.enable),
    .mode       (ctrl_r.mode),
    .first_only (ctrl_r.first_only),
    .count      (count),
    .max_r      (max_r),
    .hold_val   (hold_val),
    .dir_up     (dir_up),
    .flags      (flags),
    .first_done (first_idx_done),
    .irq        (irq)
);

// File: tb/tb_qdec_poscnt.sv
module tb_qdec_poscnt;
    localparam int W = 32;
    localparam int K_CNT = 0, K_HOLD = 1, K_LAT = 2, K_DIR = 3, K_FLG = 4, K_IRQ = 5, K_FIRST = 6;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         ph_a = 0, ph_b = 0, ph_idx = 0, hold_req = 0;
    logic         wr_en = 0;
    logic [2:0]   wr_sel = 0;
    logic [W-1:0] wr_data = 0;
    logic [W-1:0] count, hold_val, latch_val;
    logic         dir_up, first_idx_done, irq;
    logic [4:0]   flags;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        int          kind;
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t sb[$];
    item_t it;

    always #5 clk = ~clk;

    qdec_poscnt #(.W(W)) dut (
        .clk(clk), .rst(rst), .ph_a(ph_a), .ph_b(ph_b), .ph_idx(ph_idx),
        .hold_req(hold_req), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .count(count), .hold_val(hold_val), .latch_val(latch_val), .dir_up(dir_up),
        .flags(flags), .first_idx_done(first_idx_done), .irq(irq)
    );

    function automatic logic [31:0] observe(int k);
        case (k)
            K_CNT:   return count;
            K_HOLD:  return hold_val;
            K_LAT:   return latch_val;
            K_DIR:   return {31'b0, dir_up};
            K_FLG:   return {27'b0, flags};
            K_IRQ:   return {31'b0, irq};
            default: return {31'b0, first_idx_done};
        endcase
    endfunction

    // monitor: compares queued expectations away from the active edge
    always @(negedge clk) begin
        while (sb.size() > 0) begin
            it = sb.pop_front();
            checks++;
            if (observe(it.kind) !== it.exp) begin
                errors++;
                $display("FAIL %s got=%0h exp=%0h", it.tag, observe(it.kind), it.exp);
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic expect_v(int k, logic [31:0] e, string tag);
        item_t x;
        x.kind = k; x.exp = e; x.tag = tag;
        sb.push_back(x);
    endtask

    task automatic wr(logic [2:0] s, logic [31:0] d);
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic ab(logic a, logic b);
        ph_a = a; ph_b = b;
        tick();
    endtask

    task automatic idx_pulse();
        ph_idx = 1'b1; tick();
    endtask

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        tick();
        expect_v(K_CNT, 0, "R1 count");
        expect_v(K_FLG, 0, "R1 flags");
        expect_v(K_DIR, 1, "R1 dir");
        expect_v(K_IRQ, 0, "R1 irq");
        expect_v(K_HOLD, 0, "R1 hold");

        wr(3'd0, 100);
        expect_v(K_CNT, 100, "R2 write while disabled");
        wr(3'd3, 32'h1);
        wr(3'd0, 5);
        expect_v(K_CNT, 100, "R2 write ignored while enabled");

        ab(1, 0); ab(1, 1); ab(0, 1); ab(0, 0);
        expect_v(K_CNT, 104, "R3 x4 forward");
        expect_v(K_DIR, 1, "R3 dir up");
        expect_v(K_FLG, 0, "R3 no flags");
        ab(0, 1);
        expect_v(K_CNT, 103, "R3 x4 first reverse step");
        ab(1, 1); ab(1, 0); ab(0, 0);
        expect_v(K_CNT, 100, "R3 x4 reverse");
        expect_v(K_DIR, 0, "R3 dir down");
        expect_v(K_FLG, 32'h08, "R10 direction change flag");

        ab(1, 1);
        expect_v(K_FLG, 32'h18, "R10 phase error flag");
        expect_v(K_CNT, 100, "R10 phase error no count");
        ab(0, 0);
        wr(3'd4, 32'h1F);
        expect_v(K_FLG, 0, "R10 write-one clear");
        expect_v(K_IRQ, 0, "R11 irq low after clear");

        wr(3'd3, 32'h10001);
        ab(1, 1);
        expect_v(K_IRQ, 1, "R11 irq on enabled flag");
        ab(0, 0);
        wr(3'd4, 32'h1F);
        expect_v(K_IRQ, 0, "R11 irq drops");

        wr(3'd3, 0);
        wr(3'd0, 32'hFFFF_FFFF);
        wr(3'd3, 32'h1);
        ab(1, 0);
        expect_v(K_CNT, 0, "R5 free overflow");
        expect_v(K_FLG, 32'h0C, "R5 wrap flag");
        ab(0, 0);
        expect_v(K_CNT, 32'hFFFF_FFFF, "R5 free underflow");
        wr(3'd4, 32'h1F);

        wr(3'd1, 3);
        wr(3'd2, 9);
        wr(3'd3, 0);
        wr(3'd0, 9);
        wr(3'd3, 32'h15);
        ab(1, 0);
        expect_v(K_CNT, 0, "R5 bounded overflow at max");
        ab(0, 0);
        expect_v(K_CNT, 9, "R5 bounded underflow to max");
        ab(0, 1);
        expect_v(K_CNT, 8, "R5 bounded step down");
        ab(1, 1); ab(1, 0); ab(0, 0); ab(0, 1); ab(1, 1);
        expect_v(K_CNT, 3, "R6 count at compare");
        expect_v(K_FLG, 32'h0E, "R6 compare flag");
        wr(3'd4, 32'h1F);

        wr(3'd3, 32'h3);
        ab(1, 0);
        expect_v(K_CNT, 3, "R4 x2 ignores B edge");
        ab(0, 0);
        expect_v(K_CNT, 2, "R4 x2 counts A edge");

        wr(3'd3, 32'hA1);
        idx_pulse();
        expect_v(K_CNT, 9, "R7 reload max when down");
        expect_v(K_LAT, 2, "R8 latch pre-update count");
        expect_v(K_FLG, 32'h01, "R8 index flag");
        ph_idx = 0; tick();
        ab(1, 0);
        expect_v(K_CNT, 10, "R3 up step before index");
        idx_pulse();
        expect_v(K_CNT, 0, "R7 reload zero when up");
        expect_v(K_LAT, 10, "R8 latch second index");
        ph_idx = 0; tick();

        wr(3'd3, 0);
        wr(3'd3, 32'hE1);
        ab(1, 1);
        idx_pulse();
        expect_v(K_CNT, 0, "R7 first index reloads");
        expect_v(K_FIRST, 1, "R7 first-index output");
        ph_idx = 0; tick();
        ab(0, 1);
        idx_pulse();
        expect_v(K_CNT, 1, "R7 later index no reload");
        expect_v(K_LAT, 1, "R8 latch still active");
        ph_idx = 0; tick();

        hold_req = 1; tick();
        expect_v(K_HOLD, 1, "R9 external hold capture");
        ab(0, 0);
        expect_v(K_CNT, 2, "R3 up step");
        expect_v(K_HOLD, 1, "R9 held request no recapture");
        wr(3'd5, 1);
        expect_v(K_HOLD, 2, "R9 software hold capture");
        hold_req = 0; tick();

        wr(3'd3, 0);
        ab(1, 0);
        expect_v(K_CNT, 2, "R2 disabled does not count");
        ab(0, 0);

        wr(3'd3, 32'h109);
        ab(1, 0);
        expect_v(K_CNT, 3, "R12 type1 A rising up");
        ab(0, 0);
        expect_v(K_CNT, 3, "R12 type1 falling ignored");
        ab(0, 1);
        expect_v(K_CNT, 2, "R12 type1 B rising down");

        wr(3'd3, 32'hC0D);
        ab(1, 1);
        expect_v(K_CNT, 2, "R12 directional rising ignored");
        ab(0, 1);
        expect_v(K_CNT, 1, "R12 directional forced down");
        wr(3'd3, 32'h80D);
        ab(1, 1);
        ab(0, 1);
        expect_v(K_CNT, 2, "R12 directional forced up");

        wr(3'd3, 32'h20B);
        ab(1, 1);
        expect_v(K_CNT, 3, "R12 type2 B high up");
        ab(1, 0);
        expect_v(K_CNT, 3, "R12 type2 B edge ignored");
        ab(0, 0);
        expect_v(K_CNT, 2, "R12 type2 B low down");

        tick(); tick();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule